// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver

This block is the byte transport at the front of a display controller. A host sends command and data bytes over a chip-selected serial bus. A strap input picks the framing. With the strap low, every byte is eight bits long and a separate data/command line marks what kind of byte it is. With the strap high, the bus has no such line, so each frame is nine bits long and its first bit is the data/command flag. The block hands each finished byte to a downstream command decoder as a byte, a data/command flag and a one-cycle valid strobe.

All bus pins pass through two-flop synchronizers. The serial clock edges are detected in the system clock domain, so the system clock must run at least four times faster than the serial clock. Register read-back uses the same pins. When the decoder reports that a received command byte is a read command, the block stops collecting bytes. It then shifts bytes taken from `rd_data_i` out on falling serial clock edges and drives an output enable for the bidirectional data pad. Reading continues byte after byte until chip select goes high.

Top module: `serial_cmd_rx`

## Requirements
- R1: With `mode_3w_i` low, eight rising serial clock edges taken while chip select is low form one byte, first bit as bit 7. `rx_is_data_o` takes the level of `ser_dc_i` at the eighth edge: 0 marks a command and 1 marks data.
- R2: With `mode_3w_i` high, a frame is nine rising edges long. The first bit is the flag (0 command, 1 data), followed by bits 7 down to 0. `ser_dc_i` is ignored.
- R3: `rx_valid_o` pulses for exactly one system clock cycle. The pulse comes on the third rising system clock edge after the final bit's serial clock rise reaches the pins. `rx_byte_o` and `rx_is_data_o` hold their values until the next byte.
- R4: Serial clock edges that arrive while chip select is high produce no byte.
- R5: A frame cut short by chip select rising is discarded. The first frame after chip select falls again starts at its first bit.
- R6: In 8-bit mode, a command byte whose valid cycle sees `cmd_is_read_i` high starts a read. Each later falling serial clock edge drives the next bit on `ser_dout_o`, MSB first, with `ser_doe_o` high. The first bit is bit 7 of `rd_data_i`.
- R7: In 9-bit mode, a read first consumes one extra rising edge (the flag bit set to 1). Falling edges before that edge drive nothing, and `ser_doe_o` stays low.
- R8: A read may run over several bytes. Every eighth falling edge, counting from the first, takes a new byte from `rd_data_i` and pulses `rd_load_o` for one cycle. `ser_dout_o` changes only on these falling edges.
- R9: `ser_doe_o` goes low within three system clock cycles of chip select going high and stays low while chip select is high.
- R10: While a read is active, incoming rising edges produce no byte. Once chip select goes high, the block receives bytes again.
- R11: After reset, `rx_valid_o`, `rx_byte_o`, `rx_is_data_o`, `ser_dout_o`, `ser_doe_o` and `rd_load_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_3w_i | input | 1 | Framing select: 0 = 8-bit frame with D/C line, 1 = 9-bit frame |
| ser_clk_i | input | 1 | Serial clock from host |
| ser_cs_n_i | input | 1 | Chip select, active low |
| ser_dc_i | input | 1 | Data/command line (8-bit mode only) |
| ser_din_i | input | 1 | Serial data in |
| cmd_is_read_i | input | 1 | Decoder flag: current command byte is a read |
| rd_data_i | input | DATA_W | Byte to return during read-back |
| ser_dout_o | output | 1 | Serial data out during read-back |
| ser_doe_o | output | 1 | Output enable for the data pad |
| rx_byte_o | output | DATA_W | Last received byte |
| rx_is_data_o | output | 1 | 1 = data byte, 0 = command byte |
| rx_valid_o | output | 1 | One-cycle strobe for a new byte |
| rd_load_o | output | 1 | One-cycle strobe: `rd_data_i` was taken |

## Verification
The hardest state to reach from the ports is the 9-bit read lead-in. In that window a falling edge has already arrived after the command, but the flag bit has not, so the pad must stay undriven. The stimulus closes a read command, sends exactly one more clock with the data pin high, and checks the enable both before that clock and after it. Partial frames of four and five bits, cut short by chip select, test the discard rule in both framings. During read-back the bench keeps its own index of served bytes, so the prefetch on the falling edge after the last bit shows up in the load count.

// File: rtl/scrx_pkg.sv
package scrx_pkg;
    // Transfer phase within one chip-select window
    typedef enum logic [1:0] {
        PH_WRITE   = 2'd0,
        PH_RD_LEAD = 2'd1,
        PH_RD_OUT  = 2'd2
    } phase_t;
endpackage

// File: rtl/scrx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous pins.
// Assumes every bit is independent; no bus coherency is implied.
module scrx_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] stg;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first capture flop of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d_i;
            end
        end else begin : g_next
            // later flops settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];
endmodule

// File: rtl/scrx_edge.sv
// Rise/fall detector for an already synchronized level.
// Assumes the level is held at least one cycle between changes.
module scrx_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev;

    // remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev;
    assign fall_o = ~lvl_i & prev;
endmodule

// File: rtl/scrx_frame_rx.sv
// Assembles 8-bit or 9-bit frames from sampled bits, MSB first.
// Assumes bit_stb_i is only raised while the bus is selected and idle
// from read-back; restart_i drops any partial frame.
module scrx_frame_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              three_wire_i,
    input  logic              restart_i,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    input  logic              dc_pin_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              is_data_o,
    output logic              valid_o
);
    localparam int               CNT_W   = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_4W = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_3W = CNT_W'(DATA_W);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] sh;
    logic              flag_bit;
    logic [CNT_W-1:0]  last_idx;

    assign last_idx = three_wire_i ? LAST_3W : LAST_4W;

    // bit counter, shifter and byte hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            sh        <= '0;
            flag_bit  <= 1'b0;
            byte_o    <= '0;
            is_data_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (restart_i) begin
                cnt <= '0;
            end else if (bit_stb_i) begin
                if (cnt == last_idx) begin
                    cnt       <= '0;
                    valid_o   <= 1'b1;
                    byte_o    <= {sh[DATA_W-2:0], bit_val_i};
                    is_data_o <= three_wire_i ? flag_bit : dc_pin_i;
                end else begin
                    cnt <= cnt + 1'b1;
                    if (three_wire_i && cnt == '0) flag_bit <= bit_val_i;
                    else                           sh <= {sh[DATA_W-2:0], bit_val_i};
                end
            end
        end
    end

    // a strobe never lasts two cycles (R3)
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
endmodule

// File: rtl/scrx_rd_tx.sv
// Read-back shifter: takes a byte from the source at each byte start and
// moves one bit onto the pad per emit strobe, MSB first.
// Assumes emit_stb_i is one cycle per falling serial clock edge.
module scrx_rd_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              emit_stb_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              dout_o,
    output logic              doe_o,
    output logic              load_o
);
    localparam int               IDX_W    = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh;
    logic [IDX_W-1:0]  idx;

    // bit emission, byte prefetch and pad enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh     <= '0;
            idx    <= '0;
            dout_o <= 1'b0;
            doe_o  <= 1'b0;
            load_o <= 1'b0;
        end else begin
            load_o <= 1'b0;
            if (clear_i) begin
                idx   <= '0;
                doe_o <= 1'b0;
            end else if (emit_stb_i) begin
                doe_o <= 1'b1;
                if (idx == '0) begin
                    dout_o <= data_i[DATA_W-1];
                    sh     <= {data_i[DATA_W-2:0], 1'b0};
                    load_o <= 1'b1;
                end else begin
                    dout_o <= sh[DATA_W-1];
                    sh     <= {sh[DATA_W-2:0], 1'b0};
                end
                idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
            end
        end
    end

    // pad released one cycle after the deselect level (R9)
    p_oe_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !doe_o);
    // a byte is only taken while driving the pad (R8)
    p_load_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> doe_o);
    // output bit only moves on an emit strobe (R8)
    p_dout_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_stb_i |=> $stable(dout_o));
endmodule

// File: rtl/serial_cmd_rx.sv
// Dual-framing serial command receiver with register read-back.
// Assumes clk runs at least four times the serial clock so that every
// serial clock level lasts two or more clk cycles after synchronizing.
module serial_cmd_rx
    import scrx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_3w_i,
    input  logic              ser_clk_i,
    input  logic              ser_cs_n_i,
    input  logic              ser_dc_i,
    input  logic              ser_din_i,
    input  logic              cmd_is_read_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              ser_dout_o,
    output logic              ser_doe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_is_data_o,
    output logic              rx_valid_o,
    output logic              rd_load_o
);
    localparam int          PIN_N   = 4;
    localparam logic [3:0]  PIN_RST = 4'b1000;

    logic [PIN_N-1:0] pins_raw, pins_s;
    logic cs_s, sclk_s, din_s, dc_s;
    logic sclk_rise, sclk_fall, cs_rise, cs_fall;
    phase_t ph;
    logic bit_stb, emit_stb, restart;

    assign pins_raw = {ser_cs_n_i, ser_clk_i, ser_din_i, ser_dc_i};

    scrx_sync #(.W(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) i_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_raw), .q_o(pins_s));

    assign {cs_s, sclk_s, din_s, dc_s} = pins_s;

    scrx_edge #(.RST_VAL(1'b0)) i_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(sclk_s),
        .rise_o(sclk_rise), .fall_o(sclk_fall));

    scrx_edge #(.RST_VAL(1'b1)) i_cs_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(cs_s),
        .rise_o(cs_rise), .fall_o(cs_fall));

    // transfer phase: collecting, read lead-in, or shifting out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= PH_WRITE;
        end else if (cs_s) begin
            ph <= PH_WRITE;
        end else begin
            case (ph)
                PH_WRITE:
                    if (rx_valid_o && !rx_is_data_o && cmd_is_read_i)
                        ph <= mode_3w_i ? PH_RD_LEAD : PH_RD_OUT;
                PH_RD_LEAD:
                    if (sclk_rise) ph <= PH_RD_OUT;
                default: ;
            endcase
        end
    end

    assign restart  = cs_rise | cs_fall;
    assign bit_stb  = sclk_rise & ~cs_s & (ph == PH_WRITE);
    assign emit_stb = sclk_fall & ~cs_s & (ph == PH_RD_OUT);

    scrx_frame_rx #(.DATA_W(DATA_W)) i_frame (
        .clk(clk), .rst_n(rst_n), .three_wire_i(mode_3w_i),
        .restart_i(restart), .bit_stb_i(bit_stb), .bit_val_i(din_s),
        .dc_pin_i(dc_s), .byte_o(rx_byte_o), .is_data_o(rx_is_data_o),
        .valid_o(rx_valid_o));

    scrx_rd_tx #(.DATA_W(DATA_W)) i_rdtx (
        .clk(clk), .rst_n(rst_n), .clear_i(cs_s), .emit_stb_i(emit_stb),
        .data_i(rd_data_i), .dout_o(ser_dout_o), .doe_o(ser_doe_o),
        .load_o(rd_load_o));

    // no byte leaves the block while read-back owns the bus (R10)
    p_quiet_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_WRITE) |-> !rx_valid_o);
endmodule

// File: tb/test_serial_cmd_rx.sv
module test_serial_cmd_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode3 = 1'b0, sclk = 1'b0, csn = 1'b1, dcpin = 1'b0, din = 1'b0, cmd_rd = 1'b0;
    logic [7:0] rd_data;
    logic       dout, doe, rx_dc, rx_valid, rd_load;
    logic [7:0] rx_byte;

    always #2 clk = ~clk;

    serial_cmd_rx i_serial_cmd_rx (
        .clk(clk), .rst_n(rst_n), .mode_3w_i(mode3), .ser_clk_i(sclk),
        .ser_cs_n_i(csn), .ser_dc_i(dcpin), .ser_din_i(din),
        .cmd_is_read_i(cmd_rd), .rd_data_i(rd_data), .ser_dout_o(dout),
        .ser_doe_o(doe), .rx_byte_o(rx_byte), .rx_is_data_o(rx_dc),
        .rx_valid_o(rx_valid), .rd_load_o(rd_load));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int vectors = 0, miscompares = 0;
    bit ready = 1'b0;

    typedef struct { int due; logic [7:0] b; logic d; string tag; } exp_t;
    exp_t exq[$];

    logic [7:0] rd_tab [4];
    int rd_idx = 0, loads = 0;
    assign rd_data = rd_tab[rd_idx % 4];

    // reference comparison on every clock: byte strobes and read loads
    always @(negedge clk) begin
        if (ready) begin
            vectors++;
            if (exq.size() > 0 && exq[0].due == cyc) begin
                if (!(rx_valid === 1'b1 && rx_byte === exq[0].b && rx_dc === exq[0].d)) begin
                    miscompares++;
                    $display("FAIL %s: actual valid=%0b byte=%02h dc=%0b expected valid=1 byte=%02h dc=%0b",
                             exq[0].tag, rx_valid, rx_byte, rx_dc, exq[0].b, exq[0].d);
                end
                void'(exq.pop_front());
            end else if (rx_valid !== 1'b0) begin
                miscompares++;
                $display("FAIL R3 R4 R10: actual unexpected valid byte=%02h expected no valid", rx_byte);
            end
            if (rd_load === 1'b1) begin
                loads++;
                rd_idx++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output int rc);
        din = b;
        tick(3);
        sclk = 1'b1;
        rc = cyc;
        tick(2);
        sclk = 1'b0;
    endtask

    task automatic send(input bit three, input bit dc, input logic [7:0] v,
                        input bit expect_it, input string tag);
        int rc;
        dcpin = three ? 1'b0 : dc;
        if (three) clk_bit(dc, rc);
        for (int i = 7; i >= 0; i--) clk_bit(v[i], rc);
        if (expect_it) exq.push_back('{rc + 3, v, dc, tag});
    endtask

    task automatic rd_bit(input logic exp, input string tag);
        tick(3);
        check(doe === 1'b1, tag, doe, 1);
        check(dout === exp, tag, dout, exp);
        sclk = 1'b1;
        tick(2);
        sclk = 1'b0;
    endtask

    task automatic cs_low();
        csn = 1'b0;
        tick(3);
    endtask

    task automatic cs_high();
        tick(2);
        csn = 1'b1;
        tick(4);
    endtask

    // watchdog: a hung run is a failure
    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        int rc;
        rd_tab[0] = 8'hC3; rd_tab[1] = 8'h5E; rd_tab[2] = 8'h81; rd_tab[3] = 8'h27;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R11 reset state
        check(rx_valid === 1'b0, "R11 valid", rx_valid, 0);
        check(rx_byte === 8'h00, "R11 byte", rx_byte, 0);
        check(rx_dc === 1'b0, "R11 dc", rx_dc, 0);
        check(doe === 1'b0, "R11 oe", doe, 0);
        check(dout === 1'b0, "R11 dout", dout, 0);
        check(rd_load === 1'b0, "R11 load", rd_load, 0);
        ready = 1'b1;

        // R1: 8-bit framing, command then data by line level
        mode3 = 1'b0;
        cs_low();
        send(0, 0, 8'h12, 1, "R1 cmd");
        send(0, 1, 8'hA5, 1, "R1 data");
        send(0, 1, 8'h3C, 1, "R1 data");
        check(doe === 1'b0, "R6 no read without flag", doe, 0);
        cs_high();

        // R2: 9-bit framing, flag bit leads
        mode3 = 1'b1;
        cs_low();
        send(1, 0, 8'h44, 1, "R2 cmd");
        send(1, 1, 8'h0F, 1, "R2 data");
        send(1, 1, 8'hF0, 1, "R2 data");
        cs_high();

        // R4: clocks while deselected
        mode3 = 1'b0;
        send(0, 1, 8'hFF, 0, "R4");
        tick(5);
        check(exq.size() == 0, "R4 idle", exq.size(), 0);

        // R5: partial frames discarded in both framings
        cs_low();
        for (int i = 0; i < 5; i++) clk_bit(1'b1, rc);
        cs_high();
        cs_low();
        send(0, 1, 8'h96, 1, "R5 8-bit");
        cs_high();
        mode3 = 1'b1;
        cs_low();
        for (int i = 0; i < 4; i++) clk_bit(1'b1, rc);
        cs_high();
        cs_low();
        send(1, 0, 8'h5A, 1, "R5 9-bit");
        cs_high();

        // R6/R8: 8-bit read-back of three bytes
        mode3 = 1'b0;
        rd_idx = 0; loads = 0;
        cs_low();
        cmd_rd = 1'b1;
        send(0, 0, 8'h2F, 1, "R6 cmd");
        dcpin = 1'b1;
        for (int k = 0; k < 3; k++)
            for (int i = 7; i >= 0; i--)
                rd_bit(rd_tab[k][i], (k == 0) ? "R6 bit" : "R8 bit");
        tick(4);
        check(loads == 4, "R8 loads", loads, 4);
        cs_high();
        cmd_rd = 1'b0;
        check(doe === 1'b0, "R9 oe off", doe, 0);

        // R10: receiving resumes after read-back
        cs_low();
        send(0, 1, 8'h77, 1, "R10 resume");
        cs_high();

        // R7: 9-bit read-back with the flag lead-in
        mode3 = 1'b1;
        rd_idx = 0; loads = 0;
        cs_low();
        cmd_rd = 1'b1;
        send(1, 0, 8'h2D, 1, "R7 cmd");
        tick(2);
        check(doe === 1'b0, "R7 lead oe", doe, 0);
        clk_bit(1'b1, rc);
        check(doe === 1'b0, "R7 after lead", doe, 0);
        for (int k = 0; k < 2; k++)
            for (int i = 7; i >= 0; i--)
                rd_bit(rd_tab[k][i], "R7 bit");
        tick(4);
        check(loads == 3, "R8 loads 9-bit", loads, 3);
        cs_high();
        cmd_rd = 1'b0;
        check(doe === 1'b0, "R9 oe off 9-bit", doe, 0);

        tick(6);
        check(exq.size() == 0, "R3 all bytes seen", exq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule